// File: doc/BRIEF.md
# Requester Tag Pool Manager

This block owns the tags that a requester attaches to its outbound read requests. It offers one free tag at a time on a valid/ready allocation port. It watches the 96-bit descriptor that heads every completion packet and pulls the tag out of it. When the descriptor belongs to a tag that is currently outstanding, it forwards one completion event. A request answered by several split completions therefore produces several events. The tag goes back to the pool only when a descriptor carrying it has the completed flag raised. The reason (normal end, poisoned data, timeout, function reset) does not matter.

The pool is built at elaboration for either 256 tags (8-bit tags) or 1024 tags (10-bit tags). After reset every tag is free, and tags are offered in ascending order. Returned tags join the back of the queue, so a freed tag is handed out only after every tag that was already free.

A descriptor whose tag is not outstanding is a protocol violation. It produces no event, frees nothing, and sets a sticky error flag.

Top module: `tag_pool_mgr`

## Requirements
- R1: After reset all tags are free, `alloc_valid` is 1 with `alloc_tag` = 0, `evt_valid` is 0 and `proto_err` is 0.
- R2: A tag leaves the pool on a clock edge where `alloc_valid` and `alloc_ready` are both 1. `alloc_valid` is 0 exactly when no tag is free.
- R3: With `TEN_BIT`=1 the tag is rebuilt as {desc[47], desc[31], desc[71:64]}, giving a 10-bit tag.
- R4: With `TEN_BIT`=0 the tag is desc[71:64], and desc bits 31 and 47 have no effect.
- R5: A descriptor accepted for an outstanding tag yields `evt_valid`=1 on the next cycle. The event carries the tag, `evt_err` = desc[15:12], `evt_done` = desc[30] and `evt_dwords` = desc[42:32] (0 to 1024).
- R6: A descriptor with desc[30]=0 leaves its tag outstanding, so later descriptors for that tag are still accepted.
- R7: A descriptor with desc[30]=1 frees its tag whatever its error code, including 4'b1000 (function reset) and 4'b1001 (timeout).
- R8: Free tags are offered first in ascending order from reset, then in the order they were freed.
- R9: A descriptor whose tag is not outstanding produces no event and frees no tag. It sets `proto_err` on the next cycle, and `proto_err` stays set until reset.
- R10: An allocation and a free in the same cycle both take effect. A tag freed while the pool is empty is offered on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | output | 1 | A free tag is on offer |
| alloc_tag | output | TAG_W | Tag on offer |
| alloc_ready | input | 1 | Requester takes the offered tag |
| cpl_valid | input | 1 | Completion descriptor present this cycle |
| cpl_desc | input | 96 | First 12 bytes of the completion packet |
| evt_valid | output | 1 | Completion event for an outstanding tag |
| evt_tag | output | TAG_W | Tag of the event |
| evt_err | output | 4 | Error code of the completion |
| evt_done | output | 1 | Final completion of its request |
| evt_dwords | output | 11 | Payload dwords of this packet |
| proto_err | output | 1 | Sticky flag: descriptor for a tag not outstanding |

## Verification
Allocation and freeing can fall in the same cycle. In the 8-bit instance this is provoked with the pool fully drained: a descriptor with the completed flag arrives while the requester keeps `alloc_ready` high. The bench then expects no offer in that cycle and the freed tag on offer in the next one. In the 10-bit instance a final completion lands on the same edge as a grant. Its queue model must show the granted tag removed from the head and the freed tag appended at the tail. A random phase with a high grant rate keeps both pools near exhaustion, so these coincidences recur.

// File: rtl/tag_pool_pkg.sv
package tag_pool_pkg;
  localparam int DESC_W  = 96;
  localparam int ERR_W   = 4;
  localparam int DWCNT_W = 11;

  typedef struct packed {
    logic [ERR_W-1:0]   err;
    logic               done;
    logic [DWCNT_W-1:0] dwords;
  } cpl_info_t;
endpackage

// File: rtl/cpl_desc_decode.sv
module cpl_desc_decode
  import tag_pool_pkg::*;
#(
  parameter int TAG_W = 10
) (
  input  logic [DESC_W-1:0] desc_i,
  output logic [TAG_W-1:0]  tag_o,
  output cpl_info_t         info_o
);
  generate
    if (TAG_W > 8) begin : g_wide
      assign tag_o = {desc_i[47], desc_i[31], desc_i[71:64]};
    end else begin : g_narrow
      assign tag_o = desc_i[71:64];
    end
  endgenerate

  assign info_o.err    = desc_i[15:12];
  assign info_o.done   = desc_i[30];
  assign info_o.dwords = desc_i[42:32];
endmodule

// File: rtl/tag_free_list.sv
module tag_free_list #(
  parameter int NUM_TAGS = 1024,
  parameter int TAG_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pop_i,
  input  logic             push_i,
  input  logic [TAG_W-1:0] push_tag_i,
  output logic             avail_o,
  output logic [TAG_W-1:0] head_o
);
  localparam int CNT_W = $clog2(NUM_TAGS + 1);
  localparam int PTR_W = $clog2(NUM_TAGS);

  logic [TAG_W-1:0] ring_q [NUM_TAGS];
  logic [CNT_W-1:0] fresh_q, fresh_d, cnt_q, cnt_d;
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic             fresh_left, pop_ring;

  assign fresh_left = fresh_q < CNT_W'(NUM_TAGS);
  assign avail_o    = fresh_left || (cnt_q != '0);
  assign head_o     = fresh_left ? fresh_q[TAG_W-1:0] : ring_q[rd_q];
  assign pop_ring   = pop_i && !fresh_left;

  always_comb begin
    fresh_d = fresh_q;
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_q;
    if (pop_i && fresh_left) fresh_d = fresh_q + 1'b1;
    if (pop_ring) rd_d = (rd_q == PTR_W'(NUM_TAGS - 1)) ? '0 : rd_q + 1'b1;
    if (push_i)   wr_d = (wr_q == PTR_W'(NUM_TAGS - 1)) ? '0 : wr_q + 1'b1;
    case ({push_i, pop_ring})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fresh_q <= '0;
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
    end else begin
      fresh_q <= fresh_d;
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) ring_q[wr_q] <= push_tag_i;
  end

  // R8
  ring_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= fresh_q);
  // R10
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> (cnt_q < fresh_q));
endmodule

// File: rtl/tag_inuse_map.sv
module tag_inuse_map #(
  parameter int NUM_TAGS = 1024,
  parameter int TAG_W    = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic [TAG_W-1:0] set_tag_i,
  input  logic             clr_i,
  input  logic [TAG_W-1:0] clr_tag_i,
  input  logic [TAG_W-1:0] look_tag_i,
  output logic             hit_o
);
  logic [NUM_TAGS-1:0] map_q, map_d;

  assign hit_o = map_q[look_tag_i];

  always_comb begin
    map_d = map_q;
    if (set_i) map_d[set_tag_i] = 1'b1;
    if (clr_i) map_d[clr_tag_i] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  // R2
  double_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |-> !map_q[set_tag_i]);
  // R9
  free_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |-> map_q[clr_tag_i]);
endmodule

// File: rtl/tag_pool_mgr.sv
module tag_pool_mgr
  import tag_pool_pkg::*;
#(
  parameter bit TEN_BIT = 1'b1,
  localparam int TAG_W  = TEN_BIT ? 10 : 8
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               alloc_valid,
  output logic [TAG_W-1:0]   alloc_tag,
  input  logic               alloc_ready,
  input  logic               cpl_valid,
  input  logic [DESC_W-1:0]  cpl_desc,
  output logic               evt_valid,
  output logic [TAG_W-1:0]   evt_tag,
  output logic [ERR_W-1:0]   evt_err,
  output logic               evt_done,
  output logic [DWCNT_W-1:0] evt_dwords,
  output logic               proto_err
);
  localparam int NUM_TAGS = 1 << TAG_W;

  logic             alloc_fire, hit, cpl_ok, cpl_bad, free_fire;
  logic [TAG_W-1:0] d_tag;
  cpl_info_t        d_info;

  logic             evt_valid_q, evt_valid_d, proto_q, proto_d;
  logic [TAG_W-1:0] evt_tag_q;
  cpl_info_t        evt_info_q;

  cpl_desc_decode #(.TAG_W(TAG_W)) u_dec (
    .desc_i (cpl_desc),
    .tag_o  (d_tag),
    .info_o (d_info)
  );

  tag_inuse_map #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (alloc_fire),
    .set_tag_i  (alloc_tag),
    .clr_i      (free_fire),
    .clr_tag_i  (d_tag),
    .look_tag_i (d_tag),
    .hit_o      (hit)
  );

  tag_free_list #(.NUM_TAGS(NUM_TAGS), .TAG_W(TAG_W)) u_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop_i      (alloc_fire),
    .push_i     (free_fire),
    .push_tag_i (d_tag),
    .avail_o    (alloc_valid),
    .head_o     (alloc_tag)
  );

  assign alloc_fire = alloc_valid && alloc_ready;
  assign cpl_ok     = cpl_valid && hit;
  assign cpl_bad    = cpl_valid && !hit;
  assign free_fire  = cpl_ok && d_info.done;

  always_comb begin
    evt_valid_d = cpl_ok;
    proto_d     = proto_q || cpl_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_valid_q <= 1'b0;
      proto_q     <= 1'b0;
    end else begin
      evt_valid_q <= evt_valid_d;
      proto_q     <= proto_d;
    end
  end

  always_ff @(posedge clk) begin
    if (cpl_ok) begin
      evt_tag_q  <= d_tag;
      evt_info_q <= d_info;
    end
  end

  assign evt_valid  = evt_valid_q;
  assign evt_tag    = evt_tag_q;
  assign evt_err    = evt_info_q.err;
  assign evt_done   = evt_info_q.done;
  assign evt_dwords = evt_info_q.dwords;
  assign proto_err  = proto_q;

  // R5
  evt_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> $past(cpl_valid));
  // R9
  proto_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
endmodule

// File: tb/tb_tag_pool_mgr.sv
module tb_tag_pool_mgr;
  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic        alloc_ready, cpl_valid;
  logic [95:0] cpl_desc;

  logic        a10_v, e10_v, e10_done, p10;
  logic [9:0]  a10_t, e10_t;
  logic [3:0]  e10_err;
  logic [10:0] e10_dw;
  logic        a8_v, e8_v, e8_done, p8;
  logic [7:0]  a8_t, e8_t;
  logic [3:0]  e8_err;
  logic [10:0] e8_dw;

  tag_pool_mgr #(.TEN_BIT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a10_v), .alloc_tag(a10_t),
    .alloc_ready(alloc_ready), .cpl_valid(cpl_valid), .cpl_desc(cpl_desc),
    .evt_valid(e10_v), .evt_tag(e10_t), .evt_err(e10_err), .evt_done(e10_done),
    .evt_dwords(e10_dw), .proto_err(p10));

  tag_pool_mgr #(.TEN_BIT(1'b0)) dut8 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(a8_v), .alloc_tag(a8_t),
    .alloc_ready(alloc_ready), .cpl_valid(cpl_valid), .cpl_desc(cpl_desc),
    .evt_valid(e8_v), .evt_tag(e8_t), .evt_err(e8_err), .evt_done(e8_done),
    .evt_dwords(e8_dw), .proto_err(p8));

  logic o_av[2], o_ev[2], o_p[2];
  int   o_at[2], o_et[2], o_err[2], o_done[2], o_dw[2];
  always_comb begin
    o_av[0] = a10_v; o_at[0] = int'(a10_t); o_ev[0] = e10_v; o_et[0] = int'(e10_t);
    o_err[0] = int'(e10_err); o_done[0] = int'(e10_done); o_dw[0] = int'(e10_dw); o_p[0] = p10;
    o_av[1] = a8_v; o_at[1] = int'(a8_t); o_ev[1] = e8_v; o_et[1] = int'(e8_t);
    o_err[1] = int'(e8_err); o_done[1] = int'(e8_done); o_dw[1] = int'(e8_dw); o_p[1] = p8;
  end

  int nchk = 0, nerr = 0;
  int fq[2][$];
  bit used[2][1024];
  bit ev[2], ep[2];
  int et[2], eerr[2], edone[2], edw[2];
  int ntags[2] = '{1024, 256};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [95:0] build(input int t, input int err, input bit done, input int dw);
    logic [95:0] d;
    d = {$urandom, $urandom, $urandom};
    d[71:64] = t[7:0];
    d[31]    = t[8];
    d[47]    = t[9];
    d[15:12] = err[3:0];
    d[30]    = done;
    d[42:32] = dw[10:0];
    return d;
  endfunction

  task automatic model_reset();
    for (int m = 0; m < 2; m++) begin
      fq[m].delete();
      for (int t = 0; t < ntags[m]; t++) fq[m].push_back(t);
      for (int t = 0; t < 1024; t++) used[m][t] = 1'b0;
      ev[m] = 1'b0;
      ep[m] = 1'b0;
    end
  endtask

  task automatic model_check();
    for (int m = 0; m < 2; m++) begin
      chk(o_av[m] == (fq[m].size() > 0), "R2 offer", int'(o_av[m]), int'(fq[m].size() > 0));
      if (o_av[m] && fq[m].size() > 0)
        chk(o_at[m] == fq[m][0], "R8 order", o_at[m], fq[m][0]);
      chk(o_ev[m] == ev[m], "R5 event", int'(o_ev[m]), int'(ev[m]));
      if (ev[m] && o_ev[m]) begin
        chk(o_et[m] == et[m], m == 0 ? "R3 tag" : "R4 tag", o_et[m], et[m]);
        chk(o_err[m] == eerr[m], "R5 err", o_err[m], eerr[m]);
        chk(o_done[m] == edone[m], "R6 done", o_done[m], edone[m]);
        chk(o_dw[m] == edw[m], "R5 dwords", o_dw[m], edw[m]);
      end
      chk(o_p[m] == ep[m], "R9 proto", int'(o_p[m]), int'(ep[m]));
    end
  endtask

  task automatic model_step(input bit rdy, input bit v, input logic [95:0] d);
    for (int m = 0; m < 2; m++) begin
      int tg, freed;
      tg = (m == 0) ? int'({d[47], d[31], d[71:64]}) : int'(d[71:64]);
      freed = -1;
      ev[m] = 1'b0;
      if (v) begin
        if (used[m][tg]) begin
          ev[m] = 1'b1; et[m] = tg; eerr[m] = int'(d[15:12]);
          edone[m] = int'(d[30]); edw[m] = int'(d[42:32]);
          if (d[30]) begin used[m][tg] = 1'b0; freed = tg; end
        end else ep[m] = 1'b1;
      end
      if (rdy && fq[m].size() > 0) begin
        int t;
        t = fq[m].pop_front();
        used[m][t] = 1'b1;
      end
      if (freed >= 0) fq[m].push_back(freed);
    end
  endtask

  task automatic cyc(input bit rdy, input bit v, input logic [95:0] d);
    alloc_ready = rdy;
    cpl_valid   = v;
    cpl_desc    = d;
    #1;
    model_check();
    model_step(rdy, v, d);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    nerr++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int errs[9] = '{0, 1, 2, 3, 4, 5, 6, 8, 9};
    rst_n = 1'b0; alloc_ready = 1'b0; cpl_valid = 1'b0; cpl_desc = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state of both pools
    chk(a10_v == 1'b1, "R1 valid", int'(a10_v), 1);
    chk(a10_t == 10'd0, "R1 tag", int'(a10_t), 0);
    chk(e10_v == 1'b0 && p10 == 1'b0, "R1 quiet", int'(e10_v) + int'(p10), 0);
    chk(a8_v == 1'b1 && a8_t == 8'd0, "R1 narrow", int'(a8_t), 0);
    chk(e8_v == 1'b0 && p8 == 1'b0, "R1 narrow quiet", int'(e8_v) + int'(p8), 0);
    @(negedge clk);

    // drain 300 grants: narrow pool runs empty
    repeat (300) cyc(1'b1, 1'b0, '0);
    chk(a8_v == 1'b0, "R2 empty", int'(a8_v), 0);

    // R3 / R4: split completion for tag 299 with stray upper bits
    cyc(1'b0, 1'b1, build(299, 0, 1'b0, 5));
    chk(e10_v == 1'b1 && e10_t == 10'd299, "R3 rebuild", int'(e10_t), 299);
    chk(e8_v == 1'b1 && e8_t == 8'd43, "R4 ignore", int'(e8_t), 43);

    // R7 timeout with completed flag frees; R10 narrow pool refills
    cyc(1'b0, 1'b1, build(299, 9, 1'b1, 0));
    chk(e10_done == 1'b1 && e10_err == 4'd9, "R7 timeout", int'(e10_err), 9);
    chk(a8_v == 1'b1 && a8_t == 8'd43, "R10 refill", int'(a8_t), 43);

    // R6: non-final completion keeps tag 10 outstanding
    cyc(1'b0, 1'b1, build(10, 0, 1'b0, 4));
    cyc(1'b0, 1'b1, build(10, 0, 1'b1, 0));
    chk(e10_v == 1'b1 && e10_done == 1'b1, "R6 still used", int'(e10_v), 1);

    // R7: function reset code frees
    cyc(1'b0, 1'b1, build(6, 8, 1'b1, 1));
    chk(e10_err == 4'd8 && e10_done == 1'b1, "R7 freset", int'(e10_err), 8);

    // R10: grant and free on the same edge
    cyc(1'b1, 1'b1, build(7, 0, 1'b1, 2));
    chk(a10_t == 10'd301, "R10 pop", int'(a10_t), 301);

    // narrow pool: drain, then free while empty with ready held
    while (a8_v) cyc(1'b1, 1'b0, '0);
    cyc(1'b1, 1'b1, build(11, 0, 1'b1, 3));
    chk(a8_v == 1'b1 && a8_t == 8'd11, "R10 empty free", int'(a8_t), 11);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v, r;
      int t;
      r = ($urandom % 3) != 0;
      v = 1'b0;
      t = 0;
      for (int k = 0; k < 8 && !v; k++) begin
        t = int'($urandom % 1024);
        v = used[0][t] && (($urandom % 4) != 0);
      end
      cyc(r, v, build(t, errs[$urandom % 9], ($urandom % 3) == 0, int'($urandom % 1025)));
    end

    // free back a good share of tags
    for (int i = 0; i < 300; i++) begin
      bit v;
      int t;
      v = 1'b0;
      t = 0;
      for (int k = 0; k < 16 && !v; k++) begin
        t = int'($urandom % 1024);
        v = used[0][t];
      end
      cyc(1'b0, v, build(t, 0, 1'b1, 1));
    end

    // R9: orphan descriptor on the wide pool
    begin
      int t;
      t = 0;
      while (used[0][t] && t < 1023) t++;
      cyc(1'b0, 1'b1, build(t, 0, 1'b1, 1));
      chk(p10 == 1'b1, "R9 flag", int'(p10), 1);
      chk(e10_v == 1'b0, "R9 no event", int'(e10_v), 0);
      repeat (3) cyc(1'b0, 1'b0, '0);
      chk(p10 == 1'b1, "R9 sticky", int'(p10), 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule